// File: doc/BRIEF.md
# Pulse-Coded Serial ADC Controller

This block is the host side of a 12-bit sampling converter that has only three digital wires: a conversion-start pin, a serial clock input and a serial data output. The converter has no configuration register. Its input channel, or its unipolar/bipolar polarity, is chosen by the shape of the pulse on the start pin. A single long high level selects the primary setting. A short high, a short low and then the long high select the alternate setting.

A user issues a request with a one-bit select. The controller plays the matching start-pin pattern and holds the pin high for the acquisition time. The falling edge starts the conversion, and the controller then waits out the conversion time. After that it produces exactly twelve serial clock pulses and collects the bits MSB first. It returns a 16-bit result together with a one-cycle valid strobe and the select it used. Every duration is a parameter in nanoseconds and is rounded up to whole system-clock cycles.

The converter forces the alternate setting if a new start edge arrives before all twelve bits have been read. For this reason the controller never raises the start pin again until the readout is complete.

Top module: `adc_pinsel_ctrl`

## Requirements
- R1: A request with `req_alt`=0 raises `cnv_start` once and holds it high for exactly ACQ cycles (acquisition time rounded up to clock cycles), then lowers it, with no prelude pulse.
- R2: A request with `req_alt`=1 drives `cnv_start` high for PRE cycles, low for PRE cycles, then high for ACQ cycles before lowering it, where PRE is the prelude width rounded up to clock cycles.
- R3: `sclk` stays low from the falling edge of `cnv_start` until at least CONV cycles (the conversion wait rounded up) have elapsed, and it is low whenever no readout is in progress.
- R4: Each conversion produces exactly twelve `sclk` pulses, each high for SCLK_HALF cycles and low for SCLK_HALF cycles. `sdata` is captured at the falling edge of each pulse, and the first bit captured is the result MSB (bit 11).
- R5: With `req_alt`=0 the 12-bit code is treated as straight binary: `res_data[11:0]` is the code and `res_data[15:12]` is zero.
- R6: With `req_alt`=1 the code is two's complement: `res_data[11:0]` is the code and `res_data[15:12]` copies bit 11.
- R7: `res_valid` is high for exactly one cycle per accepted request, and `res_alt` then equals the accepted `req_alt`. `busy` is high from the cycle after acceptance until the valid cycle, and low in that cycle.
- R8: A request presented while `busy` is high is ignored: it produces no extra start-pin edge, no extra result and no change to the tag of the result in flight.
- R9: A synchronous reset drives `cnv_start`, `sclk`, `busy` and `res_valid` low at the next clock edge from any state, and the controller then accepts requests normally.
- R10: `cnv_start` never rises while a readout of the previous conversion is incomplete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Conversion request, taken when busy is low |
| req_alt | input | 1 | Select: 0 primary input/unipolar, 1 alternate input/bipolar |
| busy | output | 1 | A request is in progress |
| cnv_start | output | 1 | Conversion-start pin to the converter |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Zero- or sign-extended result |
| res_alt | output | 1 | Select used for this result |

## Verification
The assertions check on every cycle that the serial clock is silent outside a readout and that the start pin stays low through conversion and readout. They also check that the valid strobe lasts one cycle and coincides with busy falling, that the bit counter stays in range, and that reset returns the pins low. Only the bench's converter model can show the things that need wall-clock time or the decoding of the pattern. These are the acquisition and prelude widths, the conversion wait before the first clock, the setting the pulse shape actually selects, the twelve-pulse count, and the values produced under zero and sign extension. The model also shows that ignored requests leave no trace.

// File: rtl/adc_pinsel_pkg.sv
`timescale 1ns/1ps
package adc_pinsel_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE_HI,
        ST_PRE_LO,
        ST_ACQ,
        ST_CONV,
        ST_SHIFT
    } ctl_state_e;

    // Round a duration in ns up to whole clock cycles (at least one).
    function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                                 input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

endpackage

// File: rtl/adc_sclk_gen.sv
`timescale 1ns/1ps
module adc_sclk_gen #(
    parameter int unsigned HALF  = 4,
    parameter int unsigned NBITS = 12
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic sclk,
    output logic fall_stb,
    output logic last_stb
);
    localparam int unsigned HW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int unsigned BW = $clog2(NBITS + 1);

    typedef struct packed {
        logic [HW-1:0] half;
        logic [BW-1:0] bits;
        logic          lvl;
    } gen_t;

    gen_t g_q, g_d;
    logic edge_now;

    assign edge_now = run && (g_q.half == HW'(HALF - 1));
    assign fall_stb = edge_now && g_q.lvl;
    assign last_stb = fall_stb && (g_q.bits == BW'(NBITS - 1));
    assign sclk     = g_q.lvl;

    always_comb begin
        g_d = g_q;
        if (!run) begin
            g_d = '0;
        end else if (edge_now) begin
            g_d.half = '0;
            g_d.lvl  = ~g_q.lvl;
            if (g_q.lvl) begin
                g_d.bits = last_stb ? '0 : g_q.bits + 1'b1;
            end
        end else begin
            g_d.half = g_q.half + 1'b1;
        end
        if (rst) begin
            g_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        g_q <= g_d;
    end

    AST_BITS_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        g_q.bits < BW'(NBITS)); // R4
    AST_SCLK_STOPS: assert property (@(posedge clk) disable iff (rst)
        !run |=> !sclk); // R3

endmodule

// File: rtl/adc_shift_rx.sv
`timescale 1ns/1ps
module adc_shift_rx #(
    parameter int unsigned W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap,
    input  logic         din,
    output logic [W-1:0] word_nx
);
    logic [W-2:0] hold_q, hold_d;

    assign word_nx = {hold_q, din};

    always_comb begin
        hold_d = hold_q;
        if (cap) begin
            hold_d = word_nx[W-2:0];
        end
        if (rst) begin
            hold_d = '0;
        end
    end

    always_ff @(posedge clk) begin
        hold_q <= hold_d;
    end

endmodule

// File: rtl/adc_result_fmt.sv
`timescale 1ns/1ps
module adc_result_fmt #(
    parameter int unsigned RAW_W = 12,
    parameter int unsigned RES_W = 16
) (
    input  logic [RAW_W-1:0] raw,
    input  logic             signed_fmt,
    output logic [RES_W-1:0] res
);
    localparam int unsigned EXT = RES_W - RAW_W;

    generate
        if (EXT == 0) begin : g_same
            assign res = raw;
        end else begin : g_ext
            logic fill;
            assign fill = signed_fmt & raw[RAW_W-1];
            assign res  = {{EXT{fill}}, raw};
        end
    endgenerate

endmodule

// File: rtl/adc_pinsel_ctrl.sv
`timescale 1ns/1ps
module adc_pinsel_ctrl
    import adc_pinsel_pkg::*;
#(
    parameter int unsigned CLK_PS    = 5000,
    parameter int unsigned ACQ_NS    = 1400,
    parameter int unsigned PRE_NS    = 30,
    parameter int unsigned CONV_NS   = 3700,
    parameter int unsigned SCLK_HALF = 4,
    parameter int unsigned RAW_W     = 12,
    parameter int unsigned RES_W     = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_alt,
    output logic             busy,
    output logic             cnv_start,
    output logic             sclk,
    input  logic             sdata,
    output logic             res_valid,
    output logic [RES_W-1:0] res_data,
    output logic             res_alt
);
    localparam int unsigned ACQ_CYC  = ns_to_cycles(ACQ_NS, CLK_PS);
    localparam int unsigned PRE_CYC  = ns_to_cycles(PRE_NS, CLK_PS);
    localparam int unsigned CONV_CYC = ns_to_cycles(CONV_NS, CLK_PS);
    localparam int unsigned MAX_CYC  =
        (ACQ_CYC > CONV_CYC) ? ((ACQ_CYC > PRE_CYC) ? ACQ_CYC : PRE_CYC)
                             : ((CONV_CYC > PRE_CYC) ? CONV_CYC : PRE_CYC);
    localparam int unsigned TW = $clog2(MAX_CYC + 1);

    typedef struct packed {
        ctl_state_e       st;
        logic [TW-1:0]    tmr;
        logic             cnv;
        logic             busy;
        logic             valid;
        logic             alt;
        logic [RES_W-1:0] data;
    } ctl_t;

    ctl_t r_q, r_d;

    logic             run_shift;
    logic             fall_stb;
    logic             last_stb;
    logic [RAW_W-1:0] raw_word;
    logic [RES_W-1:0] fmt_word;

    assign run_shift = (r_q.st == ST_SHIFT);

    adc_sclk_gen #(.HALF(SCLK_HALF), .NBITS(RAW_W)) u_sclk (
        .clk      (clk),
        .rst      (rst),
        .run      (run_shift),
        .sclk     (sclk),
        .fall_stb (fall_stb),
        .last_stb (last_stb)
    );

    adc_shift_rx #(.W(RAW_W)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .cap     (fall_stb),
        .din     (sdata),
        .word_nx (raw_word)
    );

    adc_result_fmt #(.RAW_W(RAW_W), .RES_W(RES_W)) u_fmt (
        .raw        (raw_word),
        .signed_fmt (r_q.alt),
        .res        (fmt_word)
    );

    always_comb begin
        r_d       = r_q;
        r_d.valid = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.busy = 1'b1;
                    r_d.alt  = req_alt;
                    r_d.cnv  = 1'b1;
                    if (req_alt) begin
                        r_d.st  = ST_PRE_HI;
                        r_d.tmr = TW'(PRE_CYC - 1);
                    end else begin
                        r_d.st  = ST_ACQ;
                        r_d.tmr = TW'(ACQ_CYC - 1);
                    end
                end
            end
            ST_PRE_HI: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_PRE_LO;
                    r_d.cnv = 1'b0;
                    r_d.tmr = TW'(PRE_CYC - 1);
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_PRE_LO: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_ACQ;
                    r_d.cnv = 1'b1;
                    r_d.tmr = TW'(ACQ_CYC - 1);
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_ACQ: begin
                if (r_q.tmr == '0) begin
                    r_d.st  = ST_CONV;
                    r_d.cnv = 1'b0;
                    r_d.tmr = TW'(CONV_CYC - 1);
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_CONV: begin
                if (r_q.tmr == '0) begin
                    r_d.st = ST_SHIFT;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            ST_SHIFT: begin
                if (last_stb) begin
                    r_d.st    = ST_IDLE;
                    r_d.busy  = 1'b0;
                    r_d.valid = 1'b1;
                    r_d.data  = fmt_word;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
        if (rst) begin
            r_d    = '0;
            r_d.st = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        r_q <= r_d;
    end

    assign busy      = r_q.busy;
    assign cnv_start = r_q.cnv;
    assign res_valid = r_q.valid;
    assign res_data  = r_q.data;
    assign res_alt   = r_q.alt;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R7
    AST_BUSY_CLEAR_AT_VALID: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !busy); // R7
    AST_SCLK_ONLY_READOUT: assert property (@(posedge clk) disable iff (rst)
        (r_q.st != ST_SHIFT) |-> !sclk); // R3
    AST_START_LOW_READOUT: assert property (@(posedge clk) disable iff (rst)
        (r_q.st == ST_CONV || r_q.st == ST_SHIFT) |-> !cnv_start); // R10
    AST_RESET_PINS: assert property (@(posedge clk)
        rst |=> (!cnv_start && !sclk && !busy && !res_valid)); // R9

endmodule

// File: tb/adc_pinsel_ctrl_test.sv
`timescale 1ns/1ps
module adc_pinsel_ctrl_test;

    localparam real TCK      = 5.0;
    localparam real ACQ_EXP  = 1400.0;
    localparam real PRE_EXP  = 30.0;
    localparam real CONV_MIN = 3700.0;
    localparam real EPS      = 0.01;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_alt = 1'b0;
    logic        busy;
    logic        cnv_start;
    logic        sclk;
    logic        sdata = 1'b0;
    logic        res_valid;
    logic [15:0] res_data;
    logic        res_alt;

    int n_chk = 0;
    int n_err = 0;
    int cycles = 0;

    adc_pinsel_ctrl uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_alt   (req_alt),
        .busy      (busy),
        .cnv_start (cnv_start),
        .sclk      (sclk),
        .sdata     (sdata),
        .res_valid (res_valid),
        .res_data  (res_data),
        .res_alt   (res_alt)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural converter model
    int          m_st = 0;      // 0 idle, 1 first high, 2 prelude low, 3 final high
    realtime     rise_t = 0, lo_t = 0, conv_t = 0;
    bit          incomplete = 0;
    bit          conv_alt = 0;
    logic [11:0] m_word = '0;
    logic [11:0] code_next = '0;
    int          m_bits = 0;
    int          conv_cnt = 0;
    int          rise_cnt = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0;
            incomplete = 0;
        end
    end

    always @(posedge cnv_start) begin
        if (!rst) begin
            rise_cnt++;
            chk(!incomplete, "R10 start rose during readout", 1, 0);
            if (m_st == 2) begin
                chk(($realtime - lo_t) > PRE_EXP - EPS && ($realtime - lo_t) < PRE_EXP + EPS,
                    "R2 prelude low width ns", longint'($realtime - lo_t), longint'(PRE_EXP));
                m_st = 3;
            end else begin
                m_st = 1;
            end
            rise_t = $realtime;
        end
    end

    always @(negedge cnv_start) begin
        if (!rst) begin
            realtime dur;
            dur = $realtime - rise_t;
            if (m_st == 1 && dur < 1000.0) begin
                chk(dur > PRE_EXP - EPS && dur < PRE_EXP + EPS,
                    "R2 prelude high width ns", longint'(dur), longint'(PRE_EXP));
                m_st = 2;
                lo_t = $realtime;
            end else begin
                chk(dur > ACQ_EXP - EPS && dur < ACQ_EXP + EPS,
                    "R1 acquisition width ns", longint'(dur), longint'(ACQ_EXP));
                conv_alt = (m_st == 3);
                conv_cnt++;
                conv_t = $realtime;
                m_word = code_next;
                m_bits = 0;
                incomplete = 1;
                sdata = code_next[11];
                m_st = 0;
            end
        end
    end

    always @(posedge sclk) begin
        chk(($realtime - conv_t) > CONV_MIN - EPS, "R3 sclk before conversion end ns",
            longint'($realtime - conv_t), longint'(CONV_MIN));
    end

    always @(negedge sclk) begin
        if (!rst) begin
            m_bits++;
            m_word = m_word << 1;
            sdata = m_word[11];
            if (m_bits == 12) incomplete = 0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            n_err++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 190000);
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    task automatic do_conv(input bit alt, input logic [11:0] code, input bit inject);
        int c0, r0, w;
        logic [15:0] exp;
        while (busy) @(negedge clk);
        code_next = code;
        c0 = conv_cnt;
        r0 = rise_cnt;
        req_valid = 1'b1;
        req_alt = alt;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", busy, 1);
        if (inject) begin
            repeat (60) @(negedge clk);
            req_valid = 1'b1;
            req_alt = ~alt;
            @(negedge clk);
            req_valid = 1'b0;
        end
        w = 0;
        while (!res_valid && w < 5000) begin
            @(negedge clk);
            w++;
        end
        chk(res_valid == 1'b1, "R7 valid arrives", res_valid, 1);
        exp = alt ? {{4{code[11]}}, code} : {4'b0000, code};
        chk(res_data == exp, alt ? "R6 signed result" : "R5 unsigned result", res_data, exp);
        chk(res_alt == alt, "R7 result tag", res_alt, alt);
        chk(conv_alt == alt, alt ? "R2 model decoded alternate" : "R1 model decoded primary",
            conv_alt, alt);
        chk(m_bits == 12, "R4 twelve sclk pulses", m_bits, 12);
        chk(busy == 1'b0, "R7 busy low at valid", busy, 0);
        @(negedge clk);
        chk(res_valid == 1'b0, "R7 valid one cycle", res_valid, 0);
        repeat (20) @(negedge clk);
        chk(conv_cnt == c0 + 1, "R8 one conversion per request", conv_cnt - c0, 1);
        chk(rise_cnt == r0 + (alt ? 2 : 1), alt ? "R2 two start rises" : "R1 one start rise",
            rise_cnt - r0, alt ? 2 : 1);
        chk(busy == 1'b0, "R8 no extra request taken", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!cnv_start && !sclk && !busy && !res_valid, "R9 reset state",
            {cnv_start, sclk, busy, res_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int k = 0; k < 40; k++) begin
            logic [11:0] code;
            if (k == 0)       code = 12'h000;
            else if (k == 1)  code = 12'hFFF;
            else if (k == 2)  code = 12'h800;
            else if (k == 3)  code = 12'h7FF;
            else if (k < 16)  code = 12'(1 << (k - 4));
            else              code = 12'((k * 32'h2B7 + 32'h13) & 32'hFFF);
            do_conv(1'b0, code, (k % 7) == 3);
            do_conv(1'b1, code, (k % 5) == 2);
        end

        // Reset during acquisition
        req_valid = 1'b1; req_alt = 1'b0; code_next = 12'h5A5;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!cnv_start && !sclk && !busy && !res_valid, "R9 reset in acquisition",
            {cnv_start, sclk, busy, res_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        // Reset during readout
        req_valid = 1'b1; req_alt = 1'b1; code_next = 12'h3C3;
        @(negedge clk);
        req_valid = 1'b0;
        while (!sclk && cycles < 180000) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!cnv_start && !sclk && !busy && !res_valid, "R9 reset in readout",
            {cnv_start, sclk, busy, res_valid}, 0);
        rst = 1'b0;
        @(negedge clk);

        do_conv(1'b1, 12'h9AB, 1'b0);
        do_conv(1'b0, 12'h9AB, 1'b0);

        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule